// File: doc/BRIEF.md
# Shared-Buffer Mailbox with Per-Buffer Handover

This block sits between an 8-bit host processor and an I/O coprocessor. It holds a 4096-byte memory that both sides can reach through separate synchronous byte ports. The memory is split into eight buffers of 512 bytes, and address bits [11:9] give the buffer index. Each buffer is owned by exactly one side at a time. Only the owner may write the buffer's bytes; either side may read any byte. Because each buffer is tracked on its own, up to eight transactions can be outstanding at once.

To send a request, the host marks a buffer it owns as a command and writes the request bytes. It then passes the buffer to the coprocessor by setting that buffer's ownership bit. The coprocessor writes its answer into the same buffer and hands the buffer back by clearing the ownership bit. Each handback latches a pending bit for the host. The host interrupt is the OR of the pending bits that are enabled. For a bulk transfer, the host marks the buffer as data instead of command before handing it over.

Each port has an enable, a write strobe, a register-select bit, a 12-bit address and 8-bit write data. When the register-select bit is 1, address bits [2:0] choose a control register:
- 0: ownership
- 1: command tag
- 2: pending
- 3: interrupt enable
- 4: error flag, in bit 0

Top module: `mbox_dpbuf_top`

## Requirements
- R1: A memory write with register-select 0 stores one byte at the 12-bit address. A read returns the byte on that port's read data one clock after the address is presented. Either side may read any byte.
- R2: In the ownership register, bit i = 1 means the coprocessor owns buffer i, and bit i = 0 means the host owns it. A host write to register 0 only sets the bits written as 1. A coprocessor write to register 0 only clears the bits written as 1.
- R3: If both sides write the same ownership bit in the same cycle, the coprocessor's clear wins and the bit ends at 0.
- R4: A memory write from the side that does not own the addressed buffer changes no byte. It sets that side's sticky error flag (register 4, bit 0). That side clears its flag by writing 1 to bit 0, and a new discard in the same cycle takes precedence over the clear.
- R5: A 1 in command-tag bit i marks buffer i as holding a command or reply, and a 0 marks it as bulk data. The host writes the tag register directly, but bits of coprocessor-owned buffers keep their old value. Coprocessor writes to register 1 have no effect.
- R6: Every ownership bit that changes from 1 to 0 sets the same bit of the pending register. The host clears pending bits by writing 1 to register 2. A new handback in the same cycle as a clear takes precedence.
- R7: The interrupt output is high exactly when some pending bit is set and the same bit of the host-written enable register (register 3) is also set.
- R8: After reset, the ownership, command-tag, pending, enable and both error registers read 0, and the interrupt is low.
- R9: If one port writes a byte while the other port reads the same byte in the same cycle, the reader gets the value from before the write.
- R10: The eight buffers are independent. Several can be in flight together, and handing back some of them leaves the ownership and contents of the rest unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write strobe |
| host_reg | input | 1 | Host register select (1 = control register) |
| host_addr | input | 12 | Host byte address or register number |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the address |
| iop_en | input | 1 | Coprocessor access enable |
| iop_we | input | 1 | Coprocessor write strobe |
| iop_reg | input | 1 | Coprocessor register select |
| iop_addr | input | 12 | Coprocessor byte address or register number |
| iop_wdata | input | 8 | Coprocessor write data |
| iop_rdata | output | 8 | Coprocessor read data, one clock after the address |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench targets the following corner cases, each with the failure it would catch:
- **Set and clear of one ownership bit in the same cycle.** A design with the wrong precedence would leave the buffer stuck with the coprocessor and raise no pending bit.
- **Write by a non-owner.** A design that did not check ownership would corrupt reply bytes and would never raise the sticky error.
- **Host tag write aimed at a buffer already handed over.** This is the case where the tag must not change.
- **A handback in the same cycle as a pending clear.** A design with the wrong precedence would lose the interrupt.
- **A write and a read of the same byte in the same cycle.** A write-through memory would return the new value here instead of the old one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int NBUF       = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 12;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int IDX_W      = $clog2(NBUF);
    localparam int REG_W      = 3;

    typedef enum logic [REG_W-1:0] {
        REG_OWN  = 3'd0,
        REG_CMD  = 3'd1,
        REG_PEND = 3'd2,
        REG_IEN  = 3'd3,
        REG_ERR  = 3'd4
    } reg_id_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic              is_reg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

    typedef struct packed {
        logic own;
        logic cmd;
        logic pend;
        logic ien;
        logic err;
    } reg_wr_t;

    function automatic logic [IDX_W-1:0] buf_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: IDX_W];
    endfunction
endpackage

// File: rtl/mbox_mem.sv
module mbox_mem
    import mbox_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_q,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    // Read-before-write on both ports: a same-cycle reader sees the old byte.
    always_ff @(posedge clk) begin
        if (a_en) begin
            a_q <= store[a_addr];
            if (a_we) store[a_addr] <= a_wdata;
        end
        if (b_en) begin
            b_q <= store[b_addr];
            if (b_we) store[b_addr] <= b_wdata;
        end
    end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
#(
    parameter bit IS_HOST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req,
    input  logic [NBUF-1:0]   own,
    input  logic [NBUF-1:0]   cmd,
    input  logic [NBUF-1:0]   pend,
    input  logic [NBUF-1:0]   ien,
    input  logic              err,
    input  logic [DATA_W-1:0] mem_q,
    output logic              mem_en,
    output logic              mem_we,
    output logic              discard,
    output reg_wr_t           wr,
    output logic [DATA_W-1:0] rdata
);
    logic              owned;
    logic              reg_wr;
    logic              reg_rd_sel_q;
    logic [DATA_W-1:0] reg_val;
    logic [DATA_W-1:0] reg_q;
    logic [IDX_W-1:0]  idx;

    assign idx    = buf_of(req.addr);
    assign owned  = IS_HOST ? ~own[idx] : own[idx];
    assign mem_en = req.en & ~req.is_reg;
    assign mem_we = mem_en & req.we & owned;
    assign discard = mem_en & req.we & ~owned;
    assign reg_wr = req.en & req.we & req.is_reg;

    always_comb begin
        case (req.addr[REG_W-1:0])
            REG_OWN:  reg_val = own;
            REG_CMD:  reg_val = cmd;
            REG_PEND: reg_val = pend;
            REG_IEN:  reg_val = ien;
            REG_ERR:  reg_val = {{(DATA_W-1){1'b0}}, err};
            default:  reg_val = '0;
        endcase
    end

    generate
        if (IS_HOST) begin : g_host_wr
            always_comb begin
                wr      = '0;
                wr.own  = reg_wr && req.addr[REG_W-1:0] == REG_OWN;
                wr.cmd  = reg_wr && req.addr[REG_W-1:0] == REG_CMD;
                wr.pend = reg_wr && req.addr[REG_W-1:0] == REG_PEND;
                wr.ien  = reg_wr && req.addr[REG_W-1:0] == REG_IEN;
                wr.err  = reg_wr && req.addr[REG_W-1:0] == REG_ERR;
            end
        end else begin : g_iop_wr
            always_comb begin
                wr     = '0;
                wr.own = reg_wr && req.addr[REG_W-1:0] == REG_OWN;
                wr.err = reg_wr && req.addr[REG_W-1:0] == REG_ERR;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rd_sel_q <= 1'b0;
            reg_q        <= '0;
        end else if (req.en) begin
            reg_rd_sel_q <= req.is_reg;
            reg_q        <= reg_val;
        end
    end

    assign rdata = reg_rd_sel_q ? reg_q : mem_q;
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           h_wr,
    input  logic [DATA_W-1:0] h_wd,
    input  logic              h_discard,
    input  reg_wr_t           p_wr,
    input  logic [DATA_W-1:0] p_wd,
    input  logic              p_discard,
    output logic [NBUF-1:0]   own_q,
    output logic [NBUF-1:0]   cmd_q,
    output logic [NBUF-1:0]   pend_q,
    output logic [NBUF-1:0]   ien_q,
    output logic              h_err_q,
    output logic              p_err_q,
    output logic              irq
);
    logic [NBUF-1:0] set_m, clr_m, own_n, handback;

    assign set_m    = h_wr.own ? h_wd[NBUF-1:0] : '0;
    assign clr_m    = p_wr.own ? p_wd[NBUF-1:0] : '0;
    assign own_n    = (own_q | set_m) & ~clr_m;
    assign handback = own_q & ~own_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q   <= '0;
            cmd_q   <= '0;
            pend_q  <= '0;
            ien_q   <= '0;
            h_err_q <= 1'b0;
            p_err_q <= 1'b0;
        end else begin
            own_q <= own_n;
            if (h_wr.cmd)
                cmd_q <= (cmd_q & own_q) | (h_wd[NBUF-1:0] & ~own_q);
            pend_q <= (pend_q & ~(h_wr.pend ? h_wd[NBUF-1:0] : '0)) | handback;
            if (h_wr.ien) ien_q <= h_wd[NBUF-1:0];
            h_err_q <= (h_err_q & ~(h_wr.err & h_wd[0])) | h_discard;
            p_err_q <= (p_err_q & ~(p_wr.err & p_wd[0])) | p_discard;
        end
    end

    assign irq = |(pend_q & ien_q);
endmodule

// File: rtl/mbox_dpbuf_top.sv
module mbox_dpbuf_top
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_we,
    input  logic              host_reg,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              iop_en,
    input  logic              iop_we,
    input  logic              iop_reg,
    input  logic [ADDR_W-1:0] iop_addr,
    input  logic [DATA_W-1:0] iop_wdata,
    output logic [DATA_W-1:0] iop_rdata,
    output logic              irq
);
    port_req_t         h_req, p_req;
    reg_wr_t           h_wr, p_wr;
    logic              h_mem_en, h_mem_we, h_discard;
    logic              p_mem_en, p_mem_we, p_discard;
    logic [DATA_W-1:0] h_mem_q, p_mem_q;
    logic [NBUF-1:0]   own_q, cmd_q, pend_q, ien_q;
    logic              h_err_q, p_err_q;

    assign h_req = '{en: host_en, we: host_we, is_reg: host_reg,
                     addr: host_addr, wdata: host_wdata};
    assign p_req = '{en: iop_en, we: iop_we, is_reg: iop_reg,
                     addr: iop_addr, wdata: iop_wdata};

    mbox_port #(.IS_HOST(1'b1)) u_host_port (
        .clk(clk), .rst(rst), .req(h_req),
        .own(own_q), .cmd(cmd_q), .pend(pend_q), .ien(ien_q), .err(h_err_q),
        .mem_q(h_mem_q), .mem_en(h_mem_en), .mem_we(h_mem_we),
        .discard(h_discard), .wr(h_wr), .rdata(host_rdata)
    );

    mbox_port #(.IS_HOST(1'b0)) u_iop_port (
        .clk(clk), .rst(rst), .req(p_req),
        .own(own_q), .cmd(cmd_q), .pend(pend_q), .ien(ien_q), .err(p_err_q),
        .mem_q(p_mem_q), .mem_en(p_mem_en), .mem_we(p_mem_we),
        .discard(p_discard), .wr(p_wr), .rdata(iop_rdata)
    );

    mbox_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(clk),
        .a_en(h_mem_en), .a_we(h_mem_we), .a_addr(host_addr),
        .a_wdata(host_wdata), .a_q(h_mem_q),
        .b_en(p_mem_en), .b_we(p_mem_we), .b_addr(iop_addr),
        .b_wdata(iop_wdata), .b_q(p_mem_q)
    );

    mbox_flags u_flags (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_wd(host_wdata), .h_discard(h_discard),
        .p_wr(p_wr), .p_wd(iop_wdata), .p_discard(p_discard),
        .own_q(own_q), .cmd_q(cmd_q), .pend_q(pend_q), .ien_q(ien_q),
        .h_err_q(h_err_q), .p_err_q(p_err_q), .irq(irq)
    );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_en,
    input logic              host_we,
    input logic              host_reg,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              iop_en,
    input logic              iop_we,
    input logic              iop_reg,
    input logic [ADDR_W-1:0] iop_addr,
    input logic [DATA_W-1:0] iop_wdata,
    input logic [NBUF-1:0]   own_q,
    input logic [NBUF-1:0]   pend_q,
    input logic [NBUF-1:0]   ien_q,
    input logic              h_err_q,
    input logic              p_err_q,
    input logic              irq
);
    logic h_own_wr, p_own_wr, h_mem_wr, p_mem_wr;

    assign h_own_wr = host_en && host_we && host_reg && host_addr[REG_W-1:0] == REG_OWN;
    assign p_own_wr = iop_en && iop_we && iop_reg && iop_addr[REG_W-1:0] == REG_OWN;
    assign h_mem_wr = host_en && host_we && !host_reg;
    assign p_mem_wr = iop_en && iop_we && !iop_reg;

    genvar i;
    generate
        for (i = 0; i < NBUF; i++) begin : g_bit
            // R2: a bit only rises after a host set-write of that bit
            p_own_rise_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(own_q[i]) |-> $past(h_own_wr && host_wdata[i]));
            // R2: a bit only falls after a coprocessor clear-write of that bit
            p_own_fall_r2: assert property (@(posedge clk) disable iff (rst)
                $fell(own_q[i]) |-> $past(p_own_wr && iop_wdata[i]));
            // R3: the clear wins when both sides write the same bit
            p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
                (h_own_wr && host_wdata[i] && p_own_wr && iop_wdata[i]) |=> !own_q[i]);
            // R6: every handback latches pending
            p_pend_on_back_r6: assert property (@(posedge clk) disable iff (rst)
                $fell(own_q[i]) |-> pend_q[i]);
            // R7: an enabled handback raises the interrupt
            p_irq_on_back_r7: assert property (@(posedge clk) disable iff (rst)
                (p_own_wr && iop_wdata[i] && own_q[i] && ien_q[i]) |=> irq);
        end
    endgenerate

    // R4: discarded writes raise the writer's sticky error
    p_host_discard_r4: assert property (@(posedge clk) disable iff (rst)
        (h_mem_wr && own_q[buf_of(host_addr)]) |=> h_err_q);
    p_iop_discard_r4: assert property (@(posedge clk) disable iff (rst)
        (p_mem_wr && !own_q[buf_of(iop_addr)]) |=> p_err_q);
    // R8: cleared state right after reset
    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (own_q == '0 && pend_q == '0 && !irq && !h_err_q && !p_err_q));
endmodule

bind mbox_dpbuf_top mbox_chk u_chk (
    .clk(clk), .rst(rst),
    .host_en(host_en), .host_we(host_we), .host_reg(host_reg),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .iop_en(iop_en), .iop_we(iop_we), .iop_reg(iop_reg),
    .iop_addr(iop_addr), .iop_wdata(iop_wdata),
    .own_q(own_q), .pend_q(pend_q), .ien_q(ien_q),
    .h_err_q(h_err_q), .p_err_q(p_err_q), .irq(irq)
);

// File: tb/mbox_dpbuf_top_tb_top.sv
`timescale 1ns/1ps
module mbox_dpbuf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_en = 0, host_we = 0, host_reg = 0;
    logic [11:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        iop_en = 0, iop_we = 0, iop_reg = 0;
    logic [11:0] iop_addr = '0;
    logic [7:0]  iop_wdata = '0;
    logic [7:0]  iop_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mbox_dpbuf_top dut_i (
        .clk(clk), .rst(rst),
        .host_en(host_en), .host_we(host_we), .host_reg(host_reg),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .iop_en(iop_en), .iop_we(iop_we), .iop_reg(iop_reg),
        .iop_addr(iop_addr), .iop_wdata(iop_wdata), .iop_rdata(iop_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic r, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_en = 1; host_we = 1; host_reg = r; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    task automatic pwr(input logic r, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        iop_en = 1; iop_we = 1; iop_reg = r; iop_addr = a; iop_wdata = d;
        @(negedge clk);
        iop_en = 0; iop_we = 0;
    endtask

    task automatic hrd(input logic r, input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        host_en = 1; host_we = 0; host_reg = r; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_en = 0;
    endtask

    task automatic prd(input logic r, input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        iop_en = 1; iop_we = 0; iop_reg = r; iop_addr = a;
        @(negedge clk);
        d = iop_rdata;
        iop_en = 0;
    endtask

    // Both ports in the same cycle; returns the coprocessor read data.
    task automatic both(input logic hr, input logic [11:0] ha, input logic [7:0] hd,
                        input logic pw, input logic pr, input logic [11:0] pa,
                        input logic [7:0] pd, output logic [7:0] pq);
        @(negedge clk);
        host_en = 1; host_we = 1; host_reg = hr; host_addr = ha; host_wdata = hd;
        iop_en = 1; iop_we = pw; iop_reg = pr; iop_addr = pa; iop_wdata = pd;
        @(negedge clk);
        pq = iop_rdata;
        host_en = 0; host_we = 0; iop_en = 0; iop_we = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int r = 0; r < 5; r++) begin
            hrd(1, 12'(r), v); chk("R8 host reg after reset", v, 0);
        end
        prd(1, 12'd4, v); chk("R8 iop err after reset", v, 0);
        chk("R8 irq after reset", irq, 0);
    endtask

    task automatic t_mem();
        logic [7:0] v;
        hwr(0, 12'h005, 8'hA5);
        hwr(0, 12'hE00, 8'h3C);
        hrd(0, 12'h005, v); chk("R1 host readback buf0", v, 8'hA5);
        hrd(0, 12'hE00, v); chk("R1 host readback buf7", v, 8'h3C);
        prd(0, 12'h005, v); chk("R1 iop reads host byte", v, 8'hA5);
    endtask

    task automatic t_own();
        logic [7:0] v;
        hwr(1, 12'd0, 8'h01);
        hrd(1, 12'd0, v); chk("R2 host set", v, 8'h01);
        hwr(1, 12'd0, 8'h00);
        prd(1, 12'd0, v); chk("R2 host cannot clear", v, 8'h01);
        pwr(1, 12'd0, 8'h02);
        hrd(1, 12'd0, v); chk("R2 iop cannot set", v, 8'h01);
        pwr(1, 12'd0, 8'h01);
        hrd(1, 12'd0, v); chk("R2 iop clear", v, 8'h00);
        hrd(1, 12'd2, v); chk("R6 pending after handback", v, 8'h01);
        hwr(1, 12'd2, 8'h01);
        hrd(1, 12'd2, v); chk("R6 pending cleared", v, 8'h00);
    endtask

    task automatic t_conflict();
        logic [7:0] v;
        hwr(1, 12'd0, 8'h04);
        both(1, 12'd0, 8'h04, 1, 1, 12'd0, 8'h04, v);
        hrd(1, 12'd0, v); chk("R3 clear wins", v, 8'h00);
        hrd(1, 12'd2, v); chk("R3 pending from won clear", v, 8'h04);
        hwr(1, 12'd2, 8'h04);
    endtask

    task automatic t_discard();
        logic [7:0] v;
        hwr(0, 12'h010, 8'h11);
        pwr(0, 12'h010, 8'h77);
        hrd(0, 12'h010, v); chk("R4 iop write to host buf dropped", v, 8'h11);
        prd(1, 12'd4, v); chk("R4 iop err set", v, 1);
        hrd(1, 12'd4, v); chk("R4 host err untouched", v, 0);
        pwr(1, 12'd4, 8'h01);
        prd(1, 12'd4, v); chk("R4 iop err cleared", v, 0);
        hwr(1, 12'd0, 8'h02);
        hwr(0, 12'h200, 8'h99);
        hrd(1, 12'd4, v); chk("R4 host err set", v, 1);
        pwr(0, 12'h200, 8'h55);
        hrd(0, 12'h200, v); chk("R4 owner write kept", v, 8'h55);
        pwr(1, 12'd0, 8'h02);
        hwr(1, 12'd4, 8'h01);
        hwr(1, 12'd2, 8'h02);
        hrd(1, 12'd4, v); chk("R4 host err cleared", v, 0);
    endtask

    task automatic t_cmd();
        logic [7:0] v;
        hwr(1, 12'd1, 8'hFF);
        hrd(1, 12'd1, v); chk("R5 host writes tags", v, 8'hFF);
        hwr(1, 12'd0, 8'h80);
        hwr(1, 12'd1, 8'h00);
        hrd(1, 12'd1, v); chk("R5 handed buffer tag kept", v, 8'h80);
        pwr(1, 12'd1, 8'h00);
        prd(1, 12'd1, v); chk("R5 iop tag write ignored", v, 8'h80);
        pwr(1, 12'd0, 8'h80);
        hwr(1, 12'd1, 8'h00);
        hrd(1, 12'd1, v); chk("R5 tag clear after return", v, 8'h00);
        hwr(1, 12'd2, 8'h80);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        hwr(1, 12'd0, 8'h08);
        pwr(1, 12'd0, 8'h08);
        chk("R7 masked pending no irq", irq, 0);
        hwr(1, 12'd3, 8'h08);
        chk("R7 enable raises irq", irq, 1);
        hwr(1, 12'd2, 8'h08);
        chk("R7 clear drops irq", irq, 0);
        hwr(1, 12'd3, 8'h10);
        hwr(1, 12'd0, 8'h10);
        both(1, 12'd2, 8'h10, 1, 1, 12'd0, 8'h10, v);
        hrd(1, 12'd2, v); chk("R6 handback beats clear", v, 8'h10);
        chk("R7 irq after racing clear", irq, 1);
        hwr(1, 12'd2, 8'h10);
        hwr(1, 12'd3, 8'h00);
        chk("R7 irq low at end", irq, 0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        hwr(0, 12'h020, 8'h01);
        both(0, 12'h020, 8'h02, 0, 0, 12'h020, 8'h00, v);
        chk("R9 reader sees old byte", v, 8'h01);
        prd(0, 12'h020, v); chk("R9 new byte afterwards", v, 8'h02);
    endtask

    task automatic t_parallel();
        logic [7:0] v;
        for (int b = 0; b < 8; b++) hwr(0, 12'(b * 512), 8'(8'hC0 + b));
        hwr(1, 12'd0, 8'hFF);
        for (int b = 0; b < 8; b++) pwr(0, 12'(b * 512 + 1), 8'(8'h50 + b));
        pwr(1, 12'd0, 8'h55);
        hrd(1, 12'd0, v); chk("R10 partial handback", v, 8'hAA);
        hrd(1, 12'd2, v); chk("R10 pending per buffer", v, 8'h55);
        for (int b = 0; b < 8; b++) begin
            hrd(0, 12'(b * 512), v); chk("R10 command byte", v, 8'hC0 + b);
            hrd(0, 12'(b * 512 + 1), v); chk("R10 reply byte", v, 8'h50 + b);
        end
    endtask

    initial begin
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_mem();
        t_own();
        t_conflict();
        t_discard();
        t_cmd();
        t_irq();
        t_collide();
        t_parallel();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule